// File: doc/BRIEF.md
# I2C Bus Wedge Fault Injector

This block is a test-support bus master that leaves an I2C bus stuck on purpose in the middle of a transaction. Bus-recovery logic elsewhere on the chip can then be tried against a real stuck bus. One command picks a mode and carries a 7-bit target address, a register byte and a bit count. The block drives the open-drain lines through `scl_oe` and `sda_oe`, where 1 pulls the line low. It produces start conditions, address bytes and the chosen number of data bits. It then releases SDA, releases SCL and parks with SCL released until `cmd_clear` or reset. It reports the SDA and SCL levels it saw at the moment it parked.

Every wait uses the same timer. A settle delay of `SETTLE_CLKS` system clocks follows each line change. A stretch wait of up to `STRETCH_CLKS` clocks follows each SCL release, during which the block waits for the line to read high. The line inputs pass through a `SYNC_STAGES`-deep synchronizer.

The sequencer has eight states:

| State | Action |
|---|---|
| `ST_IDLE` | Waits for a command. |
| `ST_FETCH` | Decodes the next step of the mode's list. |
| `ST_SDA_SET` | Sets SDA for the step, then waits the settle delay. |
| `ST_SCL_REL` | Releases SCL and waits for it to read high. |
| `ST_SCL_HOLD` | Waits the settle delay with SCL high. |
| `ST_SDA_FALL` | Pulls SDA low with SCL high, then waits the settle delay. |
| `ST_SCL_LOW` | Pulls SCL low and advances the step. |
| `ST_WEDGED` | Parked. |

The transitions are:

- idle→fetch on a legal command.
- fetch→sda_set.
- sda_set→scl_rel when the settle delay ends.
- scl_rel→scl_hold when SCL reads high.
- scl_rel→wedged when SCL reads high on the park step, or when the stretch wait times out.
- scl_hold→sda_fall for a start step.
- scl_hold→scl_low for any other step.
- sda_fall→scl_low.
- scl_low→fetch.
- wedged→idle on `cmd_clear`.

Top module: `i2c_wedge_injector`

## Requirements
- R1: After reset and in idle, `scl_oe` and `sda_oe` are 0 and `busy`, `wedged` and `stretch_timeout` are 0.
- R2: `cmd_mode` encodes 0 = address-ACK wedge, 1 = read wedge and 2 = write wedge. A command with mode 3 is ignored: the block stays idle and both lines stay released.
- R3: Address-ACK wedge sends a start and then the byte {addr,0}, MSB first. On the ninth clock it releases SDA and raises SCL, then parks without ever pulling SCL low again.
- R4: Read wedge sends the following, then parks:
  - a start, then {addr,0} and one released ACK clock;
  - the register byte and one released ACK clock;
  - a repeated start, made by one clock with SDA released and then an SDA fall while SCL is high;
  - {addr,1} and one released ACK clock;
  - N clocks with SDA released.
- R5: Write wedge sends a start, {addr,0} and one released ACK clock. It then sends the top N bits of the register byte, MSB first, and parks. N = 0 parks right after the ACK clock.
- R6: A `cmd_bits` value above 8 is treated as 8.
- R7: SDA changes only while SCL is low, except for the SDA fall of a start. The block never makes an SDA rise while SCL is high.
- R8: While parked, both lines are released and SCL stays high until `cmd_clear` or reset, with `busy` = 0 and `wedged` = 1.
- R9: `final_sda` and `final_scl` hold the bus levels sampled when the block parked, and they stay stable while it stays parked.
- R10: After releasing SCL the block waits while a slave holds SCL low. If SCL is still low after `STRETCH_CLKS` clocks, it sets `stretch_timeout` and parks at once.
- R11: `cmd_valid` is ignored while busy or parked. `cmd_clear` while parked returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_mode | input | 2 | 0 address-ACK, 1 read, 2 write, 3 reserved |
| cmd_addr | input | 7 | Target address |
| cmd_reg | input | 8 | Register byte |
| cmd_bits | input | 4 | Data bit count N (clamped to 8) |
| cmd_clear | input | 1 | Leaves the parked state |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Sequence in progress |
| wedged | output | 1 | Parked with both lines released |
| stretch_timeout | output | 1 | Park was reached through a stretch timeout |
| final_scl | output | 1 | SCL level captured at park |
| final_sda | output | 1 | SDA level captured at park |

## Verification
The checker watches every cycle for the following:

- both lines are released in idle and in park;
- the captured levels do not move while parked;
- a timeout flag always comes with the parked state;
- SDA is never released while SCL is released, outside a timeout;
- `busy` rises only after a legal command strobe.

The bit order and content of each mode's sequence, the repeated start, the clamping of N and the behaviour under short and endless clock stretching can only be shown by the bench's scenarios. There, a bus monitor decodes starts, stops and sampled bits and compares them against an expected list built from the requirements.

// File: rtl/wedge_pkg.sv
package wedge_pkg;

    localparam int BYTE_BITS = 8;

    typedef enum logic [1:0] {
        MODE_ACK   = 2'd0,
        MODE_READ  = 2'd1,
        MODE_WRITE = 2'd2,
        MODE_RSVD  = 2'd3
    } wedge_mode_e;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_OUT   = 2'd1,
        OP_IN    = 2'd2,
        OP_PARK  = 2'd3
    } wedge_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SDA_SET,
        ST_SCL_REL,
        ST_SCL_HOLD,
        ST_SDA_FALL,
        ST_SCL_LOW,
        ST_WEDGED
    } wedge_state_e;

    typedef struct packed {
        wedge_op_e op;
        logic      bit_val;
    } wedge_step_t;

endpackage

// File: rtl/wedge_sync.sv
module wedge_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh <= {STAGES{RST_VAL}};
                else        sh <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh <= {STAGES{RST_VAL}};
                else        sh <= {sh[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sh[STAGES-1];
endmodule

// File: rtl/wedge_timer.sv
module wedge_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt <= '0;
        else if (load)          cnt <= load_val;
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/wedge_step_gen.sv
module wedge_step_gen
    import wedge_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  wedge_mode_e      mode,
    input  logic [6:0]       addr,
    input  logic [7:0]       regb,
    input  logic [3:0]       nbits,
    input  logic [IDX_W-1:0] idx,
    output wedge_step_t      step
);
    function automatic logic pick(input logic [7:0] b, input logic [2:0] pos);
        return b[3'd7 - pos];
    endfunction

    logic [7:0] wbyte;
    logic [7:0] rbyte;
    int         i;
    int         n;

    assign wbyte = {addr, 1'b0};
    assign rbyte = {addr, 1'b1};

    always_comb begin
        i    = int'(idx);
        n    = int'(nbits);
        step = '{op: OP_PARK, bit_val: 1'b1};
        if (i == 0) begin
            step = '{op: OP_START, bit_val: 1'b1};
        end else if (i <= 8) begin
            step = '{op: OP_OUT, bit_val: pick(wbyte, 3'(i - 1))};
        end else begin
            unique case (mode)
                MODE_WRITE: begin
                    if (i == 9)
                        step = '{op: OP_IN, bit_val: 1'b1};
                    else if (i - 10 < n)
                        step = '{op: OP_OUT, bit_val: pick(regb, 3'(i - 10))};
                end
                MODE_READ: begin
                    if (i == 9 || i == 18 || i == 28)
                        step = '{op: OP_IN, bit_val: 1'b1};
                    else if (i <= 17)
                        step = '{op: OP_OUT, bit_val: pick(regb, 3'(i - 10))};
                    else if (i == 19)
                        step = '{op: OP_START, bit_val: 1'b1};
                    else if (i <= 27)
                        step = '{op: OP_OUT, bit_val: pick(rbyte, 3'(i - 20))};
                    else if (i - 29 < n)
                        step = '{op: OP_IN, bit_val: 1'b1};
                end
                default: step = '{op: OP_PARK, bit_val: 1'b1};
            endcase
        end
    end
endmodule

// File: rtl/i2c_wedge_injector.sv
module i2c_wedge_injector
    import wedge_pkg::*;
#(
    parameter int SETTLE_CLKS  = 8,
    parameter int STRETCH_CLKS = 2000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_mode,
    input  logic [6:0] cmd_addr,
    input  logic [7:0] cmd_reg,
    input  logic [3:0] cmd_bits,
    input  logic       cmd_clear,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       busy,
    output logic       wedged,
    output logic       stretch_timeout,
    output logic       final_scl,
    output logic       final_sda
);
    localparam int MAX_WAIT  = (STRETCH_CLKS > SETTLE_CLKS) ? STRETCH_CLKS : SETTLE_CLKS;
    localparam int CNT_W     = $clog2(MAX_WAIT + 1);
    localparam int MAX_STEPS = 30 + BYTE_BITS;
    localparam int IDX_W     = $clog2(MAX_STEPS + 1);
    localparam logic [CNT_W-1:0] SETTLE_V  = CNT_W'(SETTLE_CLKS);
    localparam logic [CNT_W-1:0] STRETCH_V = CNT_W'(STRETCH_CLKS);

    wedge_state_e     state, nxt;
    wedge_mode_e      mode_q;
    logic [6:0]       addr_q;
    logic [7:0]       reg_q;
    logic [3:0]       nbits_q;
    logic [IDX_W-1:0] idx;
    wedge_step_t      op_q;
    wedge_step_t      step;
    logic             timeout_q, fin_scl_q, fin_sda_q;
    logic             scl_s, sda_s;
    logic             tmr_load, tmr_expired;
    logic [CNT_W-1:0] tmr_val;
    logic             cmd_go;

    wedge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
    wedge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

    wedge_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(tmr_val), .expired(tmr_expired));

    wedge_step_gen #(.IDX_W(IDX_W)) u_steps (
        .mode(mode_q), .addr(addr_q), .regb(reg_q),
        .nbits(nbits_q), .idx(idx), .step(step));

    assign cmd_go = cmd_valid && (cmd_mode != MODE_RSVD);

    // next-state decode
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = SETTLE_V;
        unique case (state)
            ST_IDLE: begin
                if (cmd_go) nxt = ST_FETCH;
            end
            ST_FETCH: begin
                nxt      = ST_SDA_SET;
                tmr_load = 1'b1;
            end
            ST_SDA_SET: begin
                if (tmr_expired) begin
                    nxt      = ST_SCL_REL;
                    tmr_load = 1'b1;
                    tmr_val  = STRETCH_V;
                end
            end
            ST_SCL_REL: begin
                if (scl_s) begin
                    if (op_q.op == OP_PARK) begin
                        nxt = ST_WEDGED;
                    end else begin
                        nxt      = ST_SCL_HOLD;
                        tmr_load = 1'b1;
                    end
                end else if (tmr_expired) begin
                    nxt = ST_WEDGED;
                end
            end
            ST_SCL_HOLD: begin
                if (tmr_expired) begin
                    if (op_q.op == OP_START) begin
                        nxt      = ST_SDA_FALL;
                        tmr_load = 1'b1;
                    end else begin
                        nxt = ST_SCL_LOW;
                    end
                end
            end
            ST_SDA_FALL: begin
                if (tmr_expired) nxt = ST_SCL_LOW;
            end
            ST_SCL_LOW: begin
                nxt = ST_FETCH;
            end
            ST_WEDGED: begin
                if (cmd_clear) nxt = ST_IDLE;
            end
        endcase
    end

    // state register and sequence context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            mode_q    <= MODE_ACK;
            addr_q    <= '0;
            reg_q     <= '0;
            nbits_q   <= '0;
            idx       <= '0;
            op_q      <= '{op: OP_PARK, bit_val: 1'b1};
            timeout_q <= 1'b0;
            fin_scl_q <= 1'b0;
            fin_sda_q <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && cmd_go) begin
                mode_q  <= wedge_mode_e'(cmd_mode);
                addr_q  <= cmd_addr;
                reg_q   <= cmd_reg;
                nbits_q <= (cmd_bits > 4'd8) ? 4'd8 : cmd_bits;
                idx     <= '0;
            end
            if (state == ST_FETCH)  op_q <= step;
            if (state == ST_SCL_LOW) idx <= idx + 1'b1;
            if (nxt == ST_WEDGED && state != ST_WEDGED) begin
                fin_scl_q <= scl_s;
                fin_sda_q <= sda_s;
                timeout_q <= !scl_s;
            end
            if (state == ST_WEDGED && nxt == ST_IDLE) begin
                fin_scl_q <= 1'b0;
                fin_sda_q <= 1'b0;
                timeout_q <= 1'b0;
            end
        end
    end

    // line drivers, registered from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_oe <= 1'b0;
            sda_oe <= 1'b0;
        end else begin
            unique case (nxt)
                ST_IDLE, ST_WEDGED: begin
                    scl_oe <= 1'b0;
                    sda_oe <= 1'b0;
                end
                ST_SDA_SET: begin
                    if (state == ST_FETCH)
                        sda_oe <= (step.op == OP_OUT) ? !step.bit_val : 1'b0;
                end
                ST_SCL_REL:  scl_oe <= 1'b0;
                ST_SDA_FALL: sda_oe <= 1'b1;
                ST_SCL_LOW:  scl_oe <= 1'b1;
                default: begin
                    scl_oe <= scl_oe;
                    sda_oe <= sda_oe;
                end
            endcase
        end
    end

    assign busy            = (state != ST_IDLE) && (state != ST_WEDGED);
    assign wedged          = (state == ST_WEDGED);
    assign stretch_timeout = timeout_q;
    assign final_scl       = fin_scl_q;
    assign final_sda       = fin_sda_q;
endmodule

// File: rtl/wedge_checker.sv
module wedge_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [1:0] cmd_mode,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       busy,
    input logic       wedged,
    input logic       stretch_timeout,
    input logic       final_scl,
    input logic       final_sda
);
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !wedged) |-> (!scl_oe && !sda_oe)); // R1

    AST_PARK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        wedged |-> (!scl_oe && !sda_oe && !busy)); // R8

    AST_NO_SDA_RISE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> ($past(scl_oe) || stretch_timeout)); // R7

    AST_FINAL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wedged && $past(wedged)) |-> ($stable(final_sda) && $stable(final_scl))); // R9

    AST_TIMEOUT_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
        stretch_timeout |-> wedged); // R10

    AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(cmd_valid) && ($past(cmd_mode) != 2'd3))); // R11
endmodule

bind i2c_wedge_injector wedge_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .wedged(wedged),
    .stretch_timeout(stretch_timeout), .final_scl(final_scl), .final_sda(final_sda));

// File: tb/sim_i2c_wedge_injector.sv
`timescale 1ns/1ps
module sim_i2c_wedge_injector;
    localparam int SETTLE  = 3;
    localparam int STRETCH = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic       cmd_valid = 1'b0, cmd_clear = 1'b0;
    logic [1:0] cmd_mode = 2'd0;
    logic [6:0] cmd_addr = '0;
    logic [7:0] cmd_reg = '0;
    logic [3:0] cmd_bits = '0;
    logic       scl_i, sda_i;
    logic       scl_oe, sda_oe, busy, wedged, stretch_timeout, final_scl, final_sda;

    // slave / bus model
    int   stretch_len = 0;
    int   hold_cnt = 0;
    logic scl_force = 1'b0;
    int   ack_at = 0;
    int   fall_base = 0;
    int   fall_cnt = 0;
    logic slave_scl_low, slave_sda_low;

    assign slave_scl_low = scl_force || (hold_cnt < stretch_len);
    assign slave_sda_low = (ack_at > 0) && ((fall_cnt - fall_base) >= ack_at);
    assign scl_i = !scl_oe && !slave_scl_low;
    assign sda_i = !sda_oe && !slave_sda_low;

    always @(posedge clk) begin
        if (scl_oe)              hold_cnt <= 0;
        else if (hold_cnt < 1000) hold_cnt <= hold_cnt + 1;
    end

    i2c_wedge_injector #(.SETTLE_CLKS(SETTLE), .STRETCH_CLKS(STRETCH)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
        .cmd_addr(cmd_addr), .cmd_reg(cmd_reg), .cmd_bits(cmd_bits),
        .cmd_clear(cmd_clear), .scl_i(scl_i), .sda_i(sda_i),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .wedged(wedged),
        .stretch_timeout(stretch_timeout), .final_scl(final_scl), .final_sda(final_sda));

    // scoreboard: events 0/1 = sampled bit, 2 = start, 3 = stop
    int    exp_mem [256];
    string exp_req [256];
    int    exp_wr = 0;
    int    exp_rd = 0;
    int    mon_tests = 0, mon_fails = 0;
    int    tests = 0, fails = 0;
    logic  p_scl = 1'b1, p_sda = 1'b1;

    task automatic got(input int ev);
        mon_tests++;
        if (exp_rd >= exp_wr) begin
            mon_fails++;
            $display("FAIL R7 unexpected bus event: actual %0d expected none", ev);
        end else begin
            if (exp_mem[exp_rd] != ev) begin
                mon_fails++;
                $display("FAIL %s bus event %0d: actual %0d expected %0d",
                         exp_req[exp_rd], exp_rd, ev, exp_mem[exp_rd]);
            end
            exp_rd++;
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_scl && !scl_i) fall_cnt++;
            if (!p_scl && scl_i)                         got(sda_i ? 1 : 0);
            else if (p_scl && scl_i && p_sda && !sda_i)  got(2);
            else if (p_scl && scl_i && !p_sda && sda_i)  got(3);
        end
        p_scl = scl_i;
        p_sda = sda_i;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input int v, input string r);
        exp_mem[exp_wr] = v;
        exp_req[exp_wr] = r;
        exp_wr++;
    endtask

    task automatic push_byte(input logic [7:0] b, input string r);
        for (int k = 7; k >= 0; k--) push(int'(b[k]), r);
    endtask

    task automatic pulse_cmd(input logic [1:0] m, input logic [6:0] a,
                             input logic [7:0] r, input int bits);
        @(negedge clk);
        cmd_mode  = m;
        cmd_addr  = a;
        cmd_reg   = r;
        cmd_bits  = 4'(bits);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic launch(input logic [1:0] m, input logic [6:0] a,
                          input logic [7:0] r, input int bits,
                          input int park_sda, input string req);
        int n;
        n = (bits > 8) ? 8 : bits;
        push(2, req);
        push_byte({a, 1'b0}, req);
        if (m == 2'd2) begin
            push(1, req);
            for (int k = 0; k < n; k++) push(int'(r[7-k]), req);
        end else if (m == 2'd1) begin
            push(1, req);
            push_byte(r, req);
            push(1, req);
            push(1, req);
            push(2, req);
            push_byte({a, 1'b1}, req);
            push(1, req);
            for (int k = 0; k < n; k++) push(1, req);
        end
        push(park_sda, req);
        fall_base = fall_cnt;
        pulse_cmd(m, a, r, bits);
    endtask

    task automatic wait_park(input string req);
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (wedged) break;
        end
        repeat (3) @(negedge clk);
        check(wedged == 1'b1, req, "reached park", int'(wedged), 1);
        check(exp_rd == exp_wr, req, "all expected bus events seen", exp_rd, exp_wr);
    endtask

    task automatic do_clear(input string req);
        @(negedge clk);
        cmd_clear = 1'b1;
        @(negedge clk);
        cmd_clear = 1'b0;
        repeat (3) @(negedge clk);
        check(!busy && !wedged, req, "idle after clear", int'({busy, wedged}), 0);
    endtask

    initial begin
        #(200000 * 5);
        $display("FAIL watchdog expired: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests + mon_tests + 1, fails + mon_fails + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!scl_oe && !sda_oe, "R1", "lines released", int'({scl_oe, sda_oe}), 0);
        check(!busy && !wedged, "R1", "busy/wedged low", int'({busy, wedged}), 0);
        check(!stretch_timeout, "R1", "timeout low", int'(stretch_timeout), 0);

        // R3 address-ACK wedge, slave acks after the 9th SCL fall
        ack_at = 9;
        launch(2'd0, 7'h5A, 8'h00, 0, 0, "R3");
        wait_park("R3");
        check(final_sda == 1'b0, "R9", "final sda with slave ack", int'(final_sda), 0);
        check(final_scl == 1'b1, "R9", "final scl", int'(final_scl), 1);
        check(!scl_oe && !sda_oe && !busy, "R8", "parked released", int'({scl_oe, sda_oe, busy}), 0);
        begin
            int lows = 0;
            for (int k = 0; k < 100; k++) begin
                @(negedge clk);
                if (!scl_i || !wedged) lows++;
            end
            check(lows == 0, "R8", "scl held high while parked", lows, 0);
        end
        // R11 command while parked is ignored
        pulse_cmd(2'd2, 7'h11, 8'hFF, 8);
        repeat (20) @(negedge clk);
        check(wedged && !busy, "R11", "command ignored while parked", int'({wedged, busy}), 2);
        check(exp_rd == exp_wr, "R11", "no bus activity while parked", exp_rd, exp_wr);
        do_clear("R11");
        push(3, "R9");
        ack_at = 0;
        repeat (5) @(negedge clk);

        // R5 write wedge N=3, with a command during the run (R11)
        launch(2'd2, 7'h21, 8'hB4, 3, 1, "R5");
        repeat (30) @(negedge clk);
        pulse_cmd(2'd0, 7'h7F, 8'h00, 0);
        wait_park("R5");
        check(final_sda == 1'b1, "R9", "final sda released", int'(final_sda), 1);
        check(!stretch_timeout, "R10", "no timeout", int'(stretch_timeout), 0);
        do_clear("R5");

        // R5 write wedge N=0
        launch(2'd2, 7'h3C, 8'h5A, 0, 1, "R5");
        wait_park("R5");
        do_clear("R5");

        // R4 read wedge N=5
        launch(2'd1, 7'h50, 8'hC3, 5, 1, "R4");
        wait_park("R4");
        check(final_scl == 1'b1, "R9", "final scl", int'(final_scl), 1);
        do_clear("R4");

        // R6 read wedge with N=12 clamped to 8
        launch(2'd1, 7'h0F, 8'h81, 12, 1, "R6");
        wait_park("R6");
        do_clear("R6");

        // R10 short stretch on every clock, no timeout
        stretch_len = 6;
        launch(2'd2, 7'h66, 8'h9D, 8, 1, "R10");
        wait_park("R10");
        check(!stretch_timeout, "R10", "short stretch no timeout", int'(stretch_timeout), 0);
        do_clear("R10");
        stretch_len = 0;

        // R2 reserved mode ignored
        pulse_cmd(2'd3, 7'h12, 8'h34, 4);
        repeat (20) @(negedge clk);
        check(!busy && !wedged, "R2", "reserved mode stays idle", int'({busy, wedged}), 0);
        check(!scl_oe && !sda_oe, "R2", "reserved mode lines released", int'({scl_oe, sda_oe}), 0);
        check(exp_rd == exp_wr, "R2", "no bus activity", exp_rd, exp_wr);

        // R10 endless stretch -> timeout and park
        @(negedge clk);
        scl_force = 1'b1;
        repeat (5) @(negedge clk);
        pulse_cmd(2'd2, 7'h44, 8'h00, 2);
        wait_park("R10");
        check(stretch_timeout == 1'b1, "R10", "timeout flag", int'(stretch_timeout), 1);
        check(final_scl == 1'b0, "R10", "final scl low", int'(final_scl), 0);
        check(final_sda == 1'b1, "R9", "final sda high", int'(final_sda), 1);
        do_clear("R10");
        check(!stretch_timeout, "R11", "clear drops timeout", int'(stretch_timeout), 0);
        push(1, "R10");
        scl_force = 1'b0;
        repeat (5) @(negedge clk);
        check(exp_rd == exp_wr, "R10", "release seen", exp_rd, exp_wr);

        $display("[TB] %0d tests run, %0d failed", tests + mon_tests, fails + mon_fails);
        $finish;
    end
endmodule